// File: doc/BRIEF.md
# Total-Store-Order Store Queue

This block sits between a core's single in-order request stream and one memory port. Stores are accepted into an eight-entry queue and written back later, so the core does not wait for memory on a store. Loads read memory straight away and may overtake queued stores to other addresses. A load whose address matches a queued store takes its word from the youngest such store. Three fence operations and a locked store keep the order the core asks for.

All operations share the request port, which is valid/ready. An operation is accepted on a clock edge where `req_valid` and `req_ready` are both high, and the requester must hold its fields stable until then. `req_ready` does not depend on `req_valid`. A load answers on `rsp_valid`/`rsp_data` in the cycle after it is accepted. That response cannot be back-pressured.

The memory side is a request/grant port. `mem_en` asks for an access and `mem_rdy` grants it. Write data is masked per byte by `mem_be`, and read data arrives on `mem_rdata` in the cycle after a granted read. While a request is not granted, its fields may change from one cycle to the next.

Top module: `tso_store_queue`

## Requirements
- R1: A store (op code 1) is ready whenever fewer than DEPTH stores are queued, and it is held off while the queue is full. Acceptance does not wait for memory.
- R2: Queued stores are written to memory exactly once each, in the order they were accepted. A locked store joins that same single order.
- R3: A load (op code 0) whose address matches no queued store makes a memory read in its accept cycle, even with older stores queued. Its response comes one cycle later and carries the memory word.
- R4: A load whose youngest matching queued store has all byte enables set is accepted without a memory read, even while memory is not granting. The next cycle it returns that store's data.
- R5: A load whose youngest matching queued store has only some byte enables set is held (not ready) until that store has been written. It then reads the merged word from memory.
- R6: When a load needing memory and a queued store both want the port, the load's read is the one presented.
- R7: A load fence (op code 2) is accepted only when no load response is due in the current cycle. Queued stores do not hold it.
- R8: A store fence (op code 3) is accepted only once the queue is empty. Writes continue to drain while it waits.
- R9: A full fence (op code 4) is accepted only when the queue is empty and no load response is due.
- R10: A locked store (op code 5) is accepted only when the queue is empty, no load response is due and memory grants. It writes memory directly in its accept cycle.
- R11: After reset the queue is empty, no response is pending, no memory access is requested, and a store is ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge if valid |
| req_op | input | 3 | 0 load, 1 store, 2 load fence, 3 store fence, 4 full fence, 5 locked store |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| rsp_valid | output | 1 | Load response present |
| rsp_data | output | DATA_W | Load data |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory byte enables |
| mem_rdy | input | 1 | Memory grants the access this cycle |
| mem_rdata | input | DATA_W | Read data, one cycle after a granted read |

## Verification
The assertions assume that the requester only ever presents the six defined op codes and holds each request stable until it is accepted. They also assume that the memory returns read data one cycle after granting a read. The bench drives every request through one issue task that waits for ready before it changes anything. Its memory model answers with exactly that one-cycle latency. The bench holds `mem_rdy` low on purpose to fill the queue and to keep fences and partial-match loads waiting.

// File: rtl/tso_pkg.sv
package tso_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_LFENCE = 3'd2,
    OP_SFENCE = 3'd3,
    OP_MFENCE = 3'd4,
    OP_LOCKST = 3'd5
  } op_e;
endpackage

// File: rtl/sq_fifo.sv
// Store queue storage with youngest-match address search.
module sq_fifo #(
  parameter int DEPTH  = 8,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int BW     = DW / 8,
  parameter int PW     = $clog2(DEPTH),
  parameter int CW     = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic [BW-1:0] push_be,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic [CW-1:0] count,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [BW-1:0] head_be,
  output logic          hit,
  output logic          hit_full,
  output logic [DW-1:0] hit_data
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [BW-1:0] be_q   [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
      be_q[tail_q]   <= push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= wrap_inc(tail_q);
      if (pop)  head_q <= wrap_inc(head_q);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign count     = count_q;
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign head_be   = be_q[head_q];

  // Walk oldest to youngest; later matches overwrite, so the youngest wins.
  always_comb begin
    int slot;
    hit      = 1'b0;
    hit_full = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = int'(head_q) + k;
      if (slot >= DEPTH) slot = slot - DEPTH;
      if (CW'(k) < count_q && addr_q[slot[PW-1:0]] == look_addr) begin
        hit      = 1'b1;
        hit_full = &be_q[slot[PW-1:0]];
        hit_data = data_q[slot[PW-1:0]];
      end
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < CW'(DEPTH)));

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0));
endmodule

// File: rtl/sq_arb.sv
// Request acceptance rules and memory port selection.
module sq_arb import tso_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          req_valid,
  input  op_e           op,
  input  logic [CW-1:0] count,
  input  logic          hit,
  input  logic          hit_full,
  input  logic          rsp_pend,
  input  logic          mem_rdy,
  output logic          req_ready,
  output logic          push,
  output logic          pop,
  output logic          sel_load,
  output logic          sel_lock,
  output logic          sel_drain,
  output logic          load_acc,
  output logic          fwd_acc
);
  logic empty, full;
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  always_comb begin
    case (op)
      OP_LOAD:   req_ready = hit ? hit_full : mem_rdy;
      OP_STORE:  req_ready = !full;
      OP_LFENCE: req_ready = !rsp_pend;
      OP_SFENCE: req_ready = empty;
      OP_MFENCE: req_ready = empty && !rsp_pend;
      OP_LOCKST: req_ready = empty && !rsp_pend && mem_rdy;
      default:   req_ready = 1'b1;
    endcase
  end

  assign sel_load  = req_valid && (op == OP_LOAD) && !hit;
  assign sel_lock  = !sel_load && req_valid && (op == OP_LOCKST) && empty && !rsp_pend;
  assign sel_drain = !sel_load && !sel_lock && !empty;

  assign push     = req_valid && (op == OP_STORE) && !full;
  assign pop      = sel_drain && mem_rdy;
  assign load_acc = req_valid && (op == OP_LOAD) && req_ready;
  assign fwd_acc  = load_acc && hit;
endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue import tso_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  input  logic                mem_rdy,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int BW = DATA_W / 8;
  localparam int CW = $clog2(DEPTH) + 1;

  op_e op;
  assign op = op_e'(req_op);

  logic [CW-1:0]     count;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data, hit_data;
  logic [BW-1:0]     head_be;
  logic              hit, hit_full;
  logic              push, pop, sel_load, sel_lock, sel_drain, load_acc, fwd_acc;
  logic              rsp_q, fwd_q;
  logic [DATA_W-1:0] fwd_data_q;

  sq_fifo #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(req_addr), .push_data(req_wdata), .push_be(req_be),
    .pop(pop), .look_addr(req_addr),
    .count(count), .head_addr(head_addr), .head_data(head_data), .head_be(head_be),
    .hit(hit), .hit_full(hit_full), .hit_data(hit_data)
  );

  sq_arb #(.DEPTH(DEPTH), .CW(CW)) u_arb (
    .req_valid(req_valid), .op(op), .count(count), .hit(hit), .hit_full(hit_full),
    .rsp_pend(rsp_q), .mem_rdy(mem_rdy), .req_ready(req_ready),
    .push(push), .pop(pop), .sel_load(sel_load), .sel_lock(sel_lock),
    .sel_drain(sel_drain), .load_acc(load_acc), .fwd_acc(fwd_acc)
  );

  // Single memory port: load read, locked store or queue head.
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    if (sel_load) begin
      mem_en   = 1'b1;
      mem_addr = req_addr;
      mem_be   = '1;
    end else if (sel_lock) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = req_addr;
      mem_wdata = req_wdata;
      mem_be    = req_be;
    end else if (sel_drain) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = head_addr;
      mem_wdata = head_data;
      mem_be    = head_be;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q      <= 1'b0;
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      rsp_q <= load_acc;
      fwd_q <= fwd_acc;
      if (fwd_acc) fwd_data_q <= hit_data;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_data  = fwd_q ? fwd_data_q : mem_rdata;

  assert_store_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STORE && count < CW'(DEPTH)) |-> req_ready);

  assert_read_then_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && mem_rdy) |=> (rsp_valid && !fwd_q));

  assert_fwd_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && op == OP_LOAD && hit) |-> !(mem_en && !mem_we));

  assert_partial_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_LOAD && hit && !hit_full) |-> !req_ready);

  assert_load_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_LOAD && !hit && count != '0) |-> (mem_en && !mem_we));

  assert_lfence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && op == OP_LFENCE) |-> !rsp_valid);

  assert_sfence_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && op == OP_SFENCE) |-> (count == '0));

  assert_mfence_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && op == OP_MFENCE) |-> (count == '0 && !rsp_valid));

  assert_lock_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && op == OP_LOCKST) |->
      (mem_en && mem_we && count == '0 && mem_addr == req_addr));
endmodule

// File: tb/sim_tso_store_queue.sv
`timescale 1ns/1ps
module sim_tso_store_queue;
  localparam int AW = 8, DW = 32, BW = 4, DEPTH = 8;
  localparam logic [2:0] LD = 3'd0, ST = 3'd1, LF = 3'd2, SF = 3'd3, MF = 3'd4, LK = 3'd5;

  // {op, addr, data, be, expected load data}
  localparam logic [78:0] VEC [0:15] = '{
    {ST, 8'h10, 32'h11111111, 4'hF, 32'h0},
    {ST, 8'h20, 32'h22222222, 4'hF, 32'h0},
    {LD, 8'h30, 32'h0,        4'h0, 32'hC0DE0030},
    {LD, 8'h10, 32'h0,        4'h0, 32'h11111111},
    {ST, 8'h10, 32'h33333333, 4'hF, 32'h0},
    {ST, 8'h10, 32'h44444444, 4'hF, 32'h0},
    {LD, 8'h10, 32'h0,        4'h0, 32'h44444444},
    {ST, 8'h40, 32'h000000AB, 4'h1, 32'h0},
    {LD, 8'h40, 32'h0,        4'h0, 32'hC0DE00AB},
    {SF, 8'h00, 32'h0,        4'h0, 32'h0},
    {LD, 8'h20, 32'h0,        4'h0, 32'h22222222},
    {MF, 8'h00, 32'h0,        4'h0, 32'h0},
    {LK, 8'h50, 32'h55555555, 4'hF, 32'h0},
    {LD, 8'h50, 32'h0,        4'h0, 32'h55555555},
    {LF, 8'h00, 32'h0,        4'h0, 32'h0},
    {LD, 8'h44, 32'h0,        4'h0, 32'hC0DE0044}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = ST;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BW-1:0] req_be = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic mem_en, mem_we, mem_rdy = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [BW-1:0] mem_be;

  always #4 clk = ~clk;

  tso_store_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata)
  );

  logic [DW-1:0] mem [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hC0DE0000 | 32'(i);
      mem_rdata <= '0;
    end else if (mem_en && mem_rdy) begin
      if (mem_we) begin
        for (int b = 0; b < BW; b++)
          if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
    end
  endtask

  // Expected memory write order, filled at acceptance.
  logic [AW-1:0] qa [64];
  logic [DW-1:0] qd [64];
  logic [BW-1:0] qb [64];
  int q_wr = 0, q_rd = 0;

  always @(negedge clk) begin
    if (rst_n && mem_en && mem_we && mem_rdy) begin
      if (q_rd == q_wr) chk(1'b0, "R2", "unexpected write", 32'(mem_addr), 32'hFFFFFFFF);
      else begin
        chk(mem_addr == qa[q_rd] && mem_wdata == qd[q_rd] && mem_be == qb[q_rd],
            "R2", "write order addr", 32'(mem_addr), 32'(qa[q_rd]));
        q_rd++;
      end
    end
  end

  logic acc_en, acc_we;
  logic [AW-1:0] acc_addr;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [BW-1:0] be);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_be = be;
  endtask

  task automatic wait_acc(output int stalls);
    stalls = 0;
    #1;
    while (!req_ready) begin
      @(posedge clk); #2;
      stalls++;
    end
    acc_en = mem_en; acc_we = mem_we; acc_addr = mem_addr;
    if (req_op == ST || req_op == LK) begin
      qa[q_wr] = req_addr; qd[q_wr] = req_wdata; qb[q_wr] = req_be;
      q_wr++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [BW-1:0] be, output int st);
    drive(op, a, d, be);
    wait_acc(st);
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                         input string tag, output int st);
    issue(LD, a, '0, '0, st);
    chk(rsp_valid == 1'b1, tag, "rsp valid", 32'(rsp_valid), 32'd1);
    chk(rsp_data == exp, tag, "load data", rsp_data, exp);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int st;
    logic [2:0] v_op;
    logic [AW-1:0] v_a;
    logic [DW-1:0] v_d, v_e;
    logic [BW-1:0] v_b;

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R11: idle state after reset
    chk(req_ready == 1'b1, "R11", "store ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R11", "no response", 32'(rsp_valid), 32'd0);
    chk(mem_en == 1'b0, "R11", "no mem access", 32'(mem_en), 32'd0);
    tick();

    // Table walk: mixed stores, loads, fences and a locked store
    for (int i = 0; i < 16; i++) begin
      {v_op, v_a, v_d, v_b, v_e} = VEC[i];
      issue(v_op, v_a, v_d, v_b, st);
      if (v_op == LD) begin
        chk(rsp_valid == 1'b1, "R3/R4/R5", "table rsp valid", 32'(rsp_valid), 32'd1);
        chk(rsp_data == v_e, "R3/R4/R5", "table load data", rsp_data, v_e);
      end
    end

    // R1: fill the queue while memory refuses, ninth store waits
    mem_rdy = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      issue(ST, 8'h80 + 8'(i), 32'hF0000000 + 32'(i), 4'hF, st);
      chk(st == 0, "R1", "store accepted without stall", 32'(st), 32'd0);
    end
    drive(ST, 8'h88, 32'hF0000008, 4'hF);
    #1 chk(req_ready == 1'b0, "R1", "full queue holds store", 32'(req_ready), 32'd0);
    mem_rdy = 1'b1;
    wait_acc(st);
    chk(st >= 1, "R1", "ninth store waited", 32'(st), 32'd1);
    issue(SF, '0, '0, '0, st);

    // R8: store fence waits for drain
    mem_rdy = 1'b0;
    for (int i = 0; i < 3; i++) issue(ST, 8'h90 + 8'(i), 32'h90900000 + 32'(i), 4'hF, st);
    drive(SF, '0, '0, '0);
    #1 chk(req_ready == 1'b0, "R8", "sfence held with stores", 32'(req_ready), 32'd0);
    mem_rdy = 1'b1;
    wait_acc(st);
    chk(q_rd == q_wr, "R8", "all stores written before sfence", 32'(q_rd), 32'(q_wr));

    // R3 and R6: load passes queued stores and wins the port
    mem_rdy = 1'b0;
    issue(ST, 8'hA0, 32'hA0A0A0A0, 4'hF, st);
    issue(ST, 8'hA1, 32'hA1A1A1A1, 4'hF, st);
    mem_rdy = 1'b1;
    drive(LD, 8'h30, '0, '0);
    wait_acc(st);
    chk(st == 0, "R3", "load not held by stores", 32'(st), 32'd0);
    chk(q_rd != q_wr, "R3", "stores still queued at load", 32'(q_wr - q_rd), 32'd2);
    chk(acc_en && !acc_we && acc_addr == 8'h30, "R6", "load read on port",
        32'(acc_addr), 32'h30);
    chk(rsp_valid && rsp_data == 32'hC0DE0030, "R3", "load data", rsp_data, 32'hC0DE0030);
    issue(SF, '0, '0, '0, st);

    // R4: forwarding from the youngest match while memory refuses
    mem_rdy = 1'b0;
    issue(ST, 8'hB0, 32'h12345678, 4'hF, st);
    issue(ST, 8'hB0, 32'h9ABCDEF0, 4'hF, st);
    do_load(8'hB0, 32'h9ABCDEF0, "R4", st);
    chk(st == 0, "R4", "forwarded load not stalled", 32'(st), 32'd0);
    chk(!(acc_en && !acc_we), "R4", "no memory read", 32'(acc_en && !acc_we), 32'd0);
    mem_rdy = 1'b1;
    issue(SF, '0, '0, '0, st);

    // R5: partial byte-enable match stalls until drained
    mem_rdy = 1'b0;
    issue(ST, 8'hC0, 32'h0000BB00, 4'b0010, st);
    drive(LD, 8'hC0, '0, '0);
    #1 chk(req_ready == 1'b0, "R5", "partial match held", 32'(req_ready), 32'd0);
    tick();
    #1 chk(req_ready == 1'b0, "R5", "partial match still held", 32'(req_ready), 32'd0);
    mem_rdy = 1'b1;
    wait_acc(st);
    chk(rsp_valid && rsp_data == 32'hC0DEBBC0, "R5", "merged word", rsp_data, 32'hC0DEBBC0);

    // R7: load fence waits only on a due response
    do_load(8'h31, 32'hC0DE0031, "R3", st);
    drive(LF, '0, '0, '0);
    #1 chk(req_ready == 1'b0, "R7", "lfence held by response", 32'(req_ready), 32'd0);
    wait_acc(st);
    chk(st == 1, "R7", "lfence one cycle stall", 32'(st), 32'd1);
    mem_rdy = 1'b0;
    issue(ST, 8'hD0, 32'hDDDD0000, 4'hF, st);
    issue(LF, '0, '0, '0, st);
    chk(st == 0, "R7", "lfence ignores queued stores", 32'(st), 32'd0);

    // R9: full fence needs empty queue and no response
    mem_rdy = 1'b1;
    do_load(8'h32, 32'hC0DE0032, "R6", st);
    mem_rdy = 1'b0;
    drive(MF, '0, '0, '0);
    #1 chk(req_ready == 1'b0, "R9", "mfence held by response", 32'(req_ready), 32'd0);
    tick();
    #1 chk(req_ready == 1'b0, "R9", "mfence held by store", 32'(req_ready), 32'd0);
    mem_rdy = 1'b1;
    wait_acc(st);
    chk(q_rd == q_wr, "R9", "queue empty at mfence", 32'(q_rd), 32'(q_wr));

    // R10: locked store drains first then writes directly
    mem_rdy = 1'b0;
    issue(ST, 8'hE0, 32'h0E0E0E0E, 4'hF, st);
    issue(ST, 8'hE1, 32'h0E1E1E1E, 4'hF, st);
    drive(LK, 8'hE0, 32'h77777777, 4'hF);
    #1 chk(req_ready == 1'b0, "R10", "locked store held", 32'(req_ready), 32'd0);
    mem_rdy = 1'b1;
    wait_acc(st);
    chk(st == 2, "R10", "waited for two drains", 32'(st), 32'd2);
    chk(acc_en && acc_we && acc_addr == 8'hE0, "R10", "direct write", 32'(acc_addr), 32'hE0);
    do_load(8'hE0, 32'h77777777, "R10", st);
    do_load(8'hE1, 32'h0E1E1E1E, "R2", st);

    tick();
    chk(q_rd == q_wr, "R2", "every store written", 32'(q_rd), 32'(q_wr));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule